// File: doc/BRIEF.md
# Cluster Word Serializer with Framing Mode

This block takes one 16-bit cluster word per bunch crossing and sends it out on a single serial line. It runs on a fast bit clock. The crossing timing comes from an internal phase counter that divides the bit clock by 4, 8 or 16. The ratio is chosen with a rate-select input and takes effect at the next crossing boundary. A word is loaded only at a crossing boundary, and only when the shift register is free. At a ratio of 16 a word fits inside one crossing. At a ratio of 4 it occupies four crossings. While a word is in flight, any word offered is dropped. It is not queued, so data already in the shift register is never overwritten.

A framing mode lets a receiver find word boundaries. In this mode the line carries a copy of the crossing clock: ones in the first half of each crossing and zeros in the second half. The block is built around a three-state controller with the states ST_IDLE, ST_SEND and ST_TRAIN. Its transitions are:

- IDLE_TO_TRAIN: at a boundary, when framing is requested.
- IDLE_TO_SEND: at a boundary, when a word is valid.
- SEND_RELOAD: the last bit is out at a boundary and a new word is valid.
- SEND_TO_TRAIN: the last bit is out at a boundary and framing is requested.
- SEND_TO_IDLE: the last bit is out and nothing is pending.
- TRAIN_TO_IDLE: at a boundary, when framing is released.

Top module: `clw_serializer`

## Requirements
- R1: While reset is asserted and directly after it, sdo_o is 1, ready_o is 1 and xing_clk_o is 1.
- R2: rate_sel_i code 0 gives 4 bit cycles per crossing, code 1 gives 8, and codes 2 and 3 give 16. The code is sampled in the last cycle of a crossing. xing_clk_o is 1 for the first half of each crossing's cycles and 0 for the second half. The last cycle of a crossing is the boundary cycle.
- R3: A word on word_i is loaded when word_valid_i is 1 and ready_o is 1 in a boundary cycle and train_en_i is 0. Its bit 15 appears on sdo_o in the next cycle. The remaining bits follow in descending order, one per cycle, for 16 consecutive cycles.
- R4: ready_o is 0 during a transmission, except in the cycle that carries bit 0.
- R5: A word offered while ready_o is 0 is dropped and never sent later.
- R6: A word offered in the boundary cycle that carries the previous word's bit 0 is sent from the next cycle on, with no gap on the line.
- R7: With no word in flight and framing off, sdo_o is 1.
- R8: In framing mode, sdo_o equals xing_clk_o and ready_o is 0. Words offered during framing are dropped. Framing starts and stops only at a boundary.
- R9: A framing request that arrives during a transmission takes effect only after the word's last bit, at a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 2 | Bit cycles per crossing: 0→4, 1→8, 2/3→16 |
| train_en_i | input | 1 | Request framing mode |
| word_i | input | 16 | Cluster word, first cluster byte in bits 15:8 |
| word_valid_i | input | 1 | word_i holds a word for this crossing |
| ready_o | output | 1 | Shift register free, a word can be taken |
| xing_clk_o | output | 1 | Crossing clock derived from the phase counter |
| sdo_o | output | 1 | Serial data line |

## Verification
Suppose the bit counter or the controller state goes wrong. The result shows up on sdo_o within one word time, at most 16 bit cycles: bits go missing, the line stays at 1 where a word should run, or a second word appears where the bench expects idle ones. A phase counter that is off shows up within one crossing. The framing pattern and the load instant both move against xing_clk_o, and the bench compares every sample against that output. A lockout fault, where a word is taken while busy or a dropped word is queued, changes the bit stream within the crossing that follows the offer.

// File: rtl/clw_pkg.sv
package clw_pkg;

    localparam int MAX_RATIO = 16;
    localparam int PH_W      = $clog2(MAX_RATIO);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_TRAIN = 2'd2
    } clw_state_e;

    function automatic logic [PH_W:0] clw_ratio(input logic [1:0] code);
        logic [PH_W:0] r;
        unique case (code)
            2'd0:    r = (PH_W+1)'(4);
            2'd1:    r = (PH_W+1)'(8);
            default: r = (PH_W+1)'(16);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/clw_xing_phase.sv
module clw_xing_phase
    import clw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [1:0] rate_sel_i,
    output logic       wrap_o,
    output logic       xing_clk_o
);
    logic [PH_W-1:0] phase_q;
    logic [1:0]      rate_q;
    logic [PH_W:0]   ratio;

    assign ratio      = clw_ratio(rate_q);
    assign wrap_o     = ({1'b0, phase_q} == (ratio - 1'b1));
    assign xing_clk_o = ({1'b0, phase_q} < (ratio >> 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            phase_q <= '0;
            rate_q  <= 2'd2;
        end else if (wrap_o) begin
            phase_q <= '0;
            rate_q  <= rate_sel_i;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end
endmodule

// File: rtl/clw_shifter.sv
module clw_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] din_i,
    output logic              msb_o,
    output logic              last_o
);
    localparam int CNT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    assign msb_o  = sh_q[WORD_W-1];
    assign last_o = (cnt_q == '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sh_q  <= '1;
            cnt_q <= '0;
        end else if (load_i) begin
            sh_q  <= din_i;
            cnt_q <= CNT_W'(WORD_W - 1);
        end else if (shift_i) begin
            sh_q  <= {sh_q[WORD_W-2:0], 1'b1};
            if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/clw_fsm.sv
module clw_fsm
    import clw_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       wrap_i,
    input  logic       valid_i,
    input  logic       train_i,
    input  logic       last_i,
    output clw_state_e state_o,
    output logic       load_o,
    output logic       shift_o,
    output logic       ready_o
);
    clw_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        ready_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready_o = 1'b1;
                if (wrap_i) begin
                    if (train_i) begin
                        state_d = ST_TRAIN;
                    end else if (valid_i) begin
                        load_o  = 1'b1;
                        state_d = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                shift_o = 1'b1;
                if (last_i) begin
                    ready_o = 1'b1;
                    if (wrap_i && train_i) begin
                        state_d = ST_TRAIN;
                    end else if (wrap_i && valid_i) begin
                        load_o  = 1'b1;
                        state_d = ST_SEND;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_TRAIN: begin
                if (wrap_i && !train_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/clw_serializer.sv
module clw_serializer
    import clw_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        rate_sel_i,
    input  logic              train_en_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              word_valid_i,
    output logic              ready_o,
    output logic              xing_clk_o,
    output logic              sdo_o
);
    logic       wrap_w;
    logic       xclk_w;
    logic       load_w;
    logic       shift_w;
    logic       msb_w;
    logic       last_w;
    clw_state_e state_w;

    clw_xing_phase u_phase (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rate_sel_i (rate_sel_i),
        .wrap_o     (wrap_w),
        .xing_clk_o (xclk_w)
    );

    clw_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (load_w),
        .shift_i (shift_w),
        .din_i   (word_i),
        .msb_o   (msb_w),
        .last_o  (last_w)
    );

    clw_fsm u_fsm (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wrap_i  (wrap_w),
        .valid_i (word_valid_i),
        .train_i (train_en_i),
        .last_i  (last_w),
        .state_o (state_w),
        .load_o  (load_w),
        .shift_o (shift_w),
        .ready_o (ready_o)
    );

    always_comb begin
        unique case (state_w)
            ST_SEND:  sdo_o = msb_w;
            ST_TRAIN: sdo_o = xclk_w;
            default:  sdo_o = 1'b1;
        endcase
    end

    assign xing_clk_o = xclk_w;
endmodule

// File: rtl/clw_serializer_chk.sv
module clw_serializer_chk
    import clw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       valid,
    input logic       train,
    input logic       word_msb,
    input logic       sdo,
    input logic       xclk,
    input logic       wrap,
    input clw_state_e st
);
    // R3: an accepted word makes the block busy in the following cycle
    a_r3_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && valid && !train && wrap) |=> !ready);

    // R3: the first bit on the line is the word's most significant bit
    a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && valid && !train && wrap) |=> (sdo == $past(word_msb)));

    // R8: the framing state never reports ready
    a_r8_train_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TRAIN) |-> !ready);

    // R9: framing is entered only across a crossing boundary
    a_r9_train_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == ST_TRAIN) |-> $past(wrap));

    // R2: the boundary cycle lies in the low half, and the next crossing starts high
    a_r2_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |-> !xclk);

    a_r2_start_high: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> xclk);
endmodule

bind clw_serializer clw_serializer_chk u_chk (
    .clk      (clk_i),
    .rst_n    (rst_ni),
    .ready    (ready_o),
    .valid    (word_valid_i),
    .train    (train_en_i),
    .word_msb (word_i[15]),
    .sdo      (sdo_o),
    .xclk     (xing_clk_o),
    .wrap     (wrap_w),
    .st       (state_w)
);

// File: tb/sim_clw_serializer.sv
module sim_clw_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rate_sel = 2'd2;
    logic        train_en = 1'b0;
    logic [15:0] word = 16'h0;
    logic        valid = 1'b0;
    logic        ready, xclk, sdo;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    clw_serializer u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rate_sel_i   (rate_sel),
        .train_en_i   (train_en),
        .word_i       (word),
        .word_valid_i (valid),
        .ready_o      (ready),
        .xing_clk_o   (xclk),
        .sdo_o        (sdo)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // step to the negedge inside the first cycle of a crossing
    task automatic sync_xing();
        logic prev;
        @(negedge clk);
        prev = xclk;
        forever begin
            @(negedge clk);
            if (xclk && !prev) break;
            prev = xclk;
        end
    endtask

    task automatic set_rate(input logic [1:0] code);
        rate_sel = code;
        sync_xing();
        sync_xing();
    endtask

    // collect 16 bits starting at the current negedge; optional drop of valid at a bit index
    task automatic grab(output logic [15:0] w, input int drop_at);
        for (int i = 0; i < 16; i++) begin
            w[15-i] = sdo;
            if (i == 1) chk("R4 busy during word", 32'(ready), 32'd0);
            if (i == drop_at) valid = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic idle_run(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, 32'(sdo), 32'd1);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 sdo in reset", 32'(sdo), 32'd1);
        chk("R1 ready in reset", 32'(ready), 32'd1);
        chk("R1 xing_clk in reset", 32'(xclk), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sdo after reset", 32'(sdo), 32'd1);
        chk("R7 ready idle", 32'(ready), 32'd1);
    endtask

    task automatic t_rate(input logic [1:0] code, input int ratio);
        set_rate(code);
        for (int i = 0; i < ratio; i++) begin
            chk("R2 crossing clock shape", 32'(xclk), 32'(i < ratio/2));
            @(negedge clk);
        end
        chk("R2 next crossing high", 32'(xclk), 32'd1);
    endtask

    task automatic t_send(input logic [15:0] w, input int ratio, input string req);
        logic [15:0] got;
        sync_xing();
        word = w;
        valid = 1'b1;
        repeat (ratio) @(negedge clk);
        valid = 1'b0;
        grab(got, -1);
        chk(req, 32'(got), 32'(w));
        idle_run(ratio, "R7 line idles high");
        chk("R7 ready after word", 32'(ready), 32'd1);
    endtask

    // R5 at ratio 4: a second word offered while busy is dropped
    task automatic t_lockout();
        logic [15:0] got;
        set_rate(2'd0);
        sync_xing();
        word = 16'h9C3A;
        valid = 1'b1;
        repeat (4) @(negedge clk);
        word = 16'h1234;
        grab(got, 12);
        chk("R5 word in flight intact", 32'(got), 32'h9C3A);
        idle_run(8, "R5 dropped word not sent");
    endtask

    // R6 at ratio 16: back-to-back words
    task automatic t_b2b();
        logic [15:0] a, b;
        set_rate(2'd3);
        sync_xing();
        word = 16'hFFFF;
        valid = 1'b1;
        repeat (16) @(negedge clk);
        word = 16'h4D41;
        grab(a, -1);
        grab(b, 0);
        chk("R6 first word", 32'(a), 32'hFFFF);
        chk("R6 second word no gap", 32'(b), 32'h4D41);
        idle_run(4, "R7 idle after pair");
    endtask

    task automatic t_train();
        set_rate(2'd1);
        sync_xing();
        train_en = 1'b1;
        word = 16'h0000;
        valid = 1'b1;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            chk("R8 framing pattern", 32'(sdo), 32'((i % 8) < 4));
            chk("R8 not ready in framing", 32'(ready), 32'd0);
            @(negedge clk);
        end
        valid = 1'b0;
        train_en = 1'b0;
        repeat (8) @(negedge clk);
        chk("R8 ready after framing", 32'(ready), 32'd1);
        idle_run(8, "R8 word offered in framing dropped");
    endtask

    task automatic t_defer();
        logic [15:0] got;
        sync_xing();
        word = 16'h0505;
        valid = 1'b1;
        repeat (8) @(negedge clk);
        valid = 1'b0;
        train_en = 1'b1;
        grab(got, -1);
        chk("R9 word completes before framing", 32'(got), 32'h0505);
        for (int i = 0; i < 8; i++) begin
            chk("R9 framing after word", 32'(sdo), 32'(i < 4));
            @(negedge clk);
        end
        train_en = 1'b0;
        repeat (8) @(negedge clk);
        idle_run(4, "R8 idle after framing");
    endtask

    initial begin
        t_reset();
        t_rate(2'd0, 4);
        t_rate(2'd1, 8);
        t_rate(2'd3, 16);
        set_rate(2'd2);
        t_send(16'h4D41, 16, "R3 word at ratio 16");
        set_rate(2'd1);
        t_send(16'h0505, 8, "R3 word at ratio 8");
        set_rate(2'd0);
        t_send(16'hA3C5, 4, "R4 word over four crossings");
        t_lockout();
        t_b2b();
        t_train();
        t_defer();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule